// File: doc/BRIEF.md
# Chainable Pair of Countdown Timers

This block holds two down-counters of a parameterised width (32 bits by default). Each counter can run as a timer of its own. Setting the chain input turns the pair into one timer of twice the width, with counter 1 as the upper half. Counting advances only on clock cycles where the single-cycle tick input is high, so the rate is set outside the block.

Each timer has a configuration step and a separate start. A configuration pulse captures a reload value and a mode: periodic, or single-shot. It does not begin counting. A start pulse loads the counter from the captured value and sets the channel's busy bit. A stop pulse freezes the counter and clears busy. Expiry is reported as a one-cycle pulse. A periodic timer keeps running after expiry. A single-shot timer goes idle.

In chained mode, the channel 0 controls govern the wide timer. One channel 0 configuration pulse captures both halves of the reload value, from `load0` and `load1`.

Top module: `dual_down_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both counters read 0, `busy` is 2'b00 and `expire` is 2'b00.
- R2: A pulse on `init[i]` captures the reload value and the mode (`periodic[i]`: 1 = periodic, 0 = single-shot). It leaves `busy[i]` and the counter unchanged.
- R3: A pulse on `start[i]` sets `busy[i]` and loads the counter with the captured reload value. If `init[i]` is pulsed in the same cycle, the value on the load input is used instead. A start while the timer is running reloads the counter.
- R4: A running counter changes only on cycles where `tick` is high. On such a cycle it steps down by one unless it is at zero.
- R5: `expire[i]` is high for the single cycle after a tick that leaves the counter at zero. A single-shot timer started with load L > 0 expires on its L-th tick.
- R6: In periodic mode, a tick that finds the counter at zero reloads it and does not expire. Expiry therefore repeats every L+1 ticks, and `busy[i]` stays set.
- R7: A single-shot expiry clears `busy[i]` in the same cycle that `expire[i]` rises. The counter then stays at zero whatever the tick does.
- R8: A pulse on `stop[i]` clears `busy[i]`, freezes the counter and suppresses expiry. Stop wins over a start in the same cycle.
- R9: With `cascade` low, activity on one channel never changes the other channel's counter, busy bit or expire output.
- R10: With `cascade` high, {count1,count0} is one counter. The upper half steps down only on a tick where the lower half goes from zero to all ones.
- R11: With `cascade` high, expiry is reported on `expire[0]` only when both halves are zero. The channel 1 control pulses are ignored, and `busy[1]` and `expire[1]` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per count |
| cascade | input | 1 | 1 = chain both counters into one wide timer |
| init | input | 2 | Per-channel configuration pulse |
| periodic | input | 2 | Mode captured on init, 1 = periodic |
| load0 | input | CW | Reload value for channel 0 (lower half when chained) |
| load1 | input | CW | Reload value for channel 1 (upper half when chained) |
| start | input | 2 | Per-channel start pulse |
| stop | input | 2 | Per-channel stop pulse |
| count0 | output | CW | Current value of counter 0 |
| count1 | output | CW | Current value of counter 1 |
| expire | output | 2 | One-cycle expiry pulse per channel |
| busy | output | 2 | Channel running (in use) |

## Verification
A wrong count value shows on `count0` or `count1` in the cycle right after the faulty edge. It then surfaces again as an expiry that arrives one or more ticks early or late. A running flag stuck high or low shows on `busy` at once. It also shows as a counter that keeps moving, or stays frozen, on the next tick. A bad borrow between the halves in chained mode shows on `count1` at the first tick where the lower half passes through zero. The bench therefore checks the counter values tick by tick, besides the pulse outputs.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cascade,
  input  logic [1:0]    init,
  input  logic [1:0]    periodic,
  input  logic [CW-1:0] load0,
  input  logic [CW-1:0] load1,
  input  logic [1:0]    start,
  input  logic [1:0]    stop,
  output logic [CW-1:0] count0,
  output logic [CW-1:0] count1,
  output logic [1:0]    expire,
  output logic [1:0]    busy
);

  logic [CW-1:0] cnt   [2];
  logic [CW-1:0] ld_q  [2];
  logic [CW-1:0] ld_in [2];
  logic [CW-1:0] rl    [2];
  logic [CW-1:0] nxt   [2];
  logic [1:0]    per_q, run, exp_q;
  logic [1:0]    ini_e, sta_e, sto_e, per_in, mode_e, hit, zero;
  logic          allz;

  assign ini_e  = {cascade ? init[0]     : init[1],     init[0]};
  assign sta_e  = {cascade ? start[0]    : start[1],    start[0]};
  assign sto_e  = {cascade ? stop[0]     : stop[1],     stop[0]};
  assign per_in = {cascade ? periodic[0] : periodic[1], periodic[0]};
  assign mode_e = {cascade ? per_q[0]    : per_q[1],    per_q[0]};

  assign ld_in[0] = load0;
  assign ld_in[1] = load1;

  assign zero[0] = (cnt[0] == '0);
  assign zero[1] = (cnt[1] == '0);
  assign allz    = zero[0] & zero[1];

  assign rl[0] = ini_e[0] ? ld_in[0] : ld_q[0];
  assign rl[1] = ini_e[1] ? ld_in[1] : ld_q[1];

  always_comb begin
    if (cascade) begin
      nxt[0] = allz ? ld_q[0] : cnt[0] - 1'b1;
      nxt[1] = allz ? ld_q[1] : (zero[0] ? cnt[1] - 1'b1 : cnt[1]);
      hit[0] = (nxt[0] == '0) && (nxt[1] == '0);
      hit[1] = hit[0];
    end else begin
      nxt[0] = zero[0] ? ld_q[0] : cnt[0] - 1'b1;
      nxt[1] = zero[1] ? ld_q[1] : cnt[1] - 1'b1;
      hit[0] = (nxt[0] == '0);
      hit[1] = (nxt[1] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cnt[i]  <= '0;
        ld_q[i] <= '0;
      end
      per_q <= '0;
      run   <= '0;
      exp_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        exp_q[i] <= 1'b0;
        if (ini_e[i]) begin
          ld_q[i]  <= ld_in[i];
          per_q[i] <= per_in[i];
        end
        if (sto_e[i]) begin
          run[i] <= 1'b0;
        end else if (sta_e[i]) begin
          run[i] <= 1'b1;
          cnt[i] <= rl[i];
        end else if (run[i] && tick) begin
          cnt[i] <= nxt[i];
          if (hit[i]) begin
            exp_q[i] <= 1'b1;
            if (!mode_e[i]) run[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign count0 = cnt[0];
  assign count1 = cnt[1];
  assign expire = {exp_q[1] & ~cascade, exp_q[0]};
  assign busy   = {run[1] & ~cascade, run[0]};

endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cascade,
  input logic [1:0]    start,
  input logic [1:0]    stop,
  input logic [CW-1:0] count0,
  input logic [CW-1:0] count1,
  input logic [1:0]    expire,
  input logic [1:0]    busy
);

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start[0] && !stop[0] |=> busy[0]); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] && !tick && !start[0] && !stop[0] |=> $stable(count0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0] && !start[0] |=> $stable(count0)); // R7

  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |-> (count0 == '0) && (!cascade || count1 == '0)); // R5

  AST_EXPIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |-> $past(tick)); // R5

  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    stop[0] |=> !busy[0] && !expire[0]); // R8

  AST_UPPER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cascade && busy[0] && !start[0] && !stop[0] && count0 != '0 |=> $stable(count1)); // R10

endmodule

bind dual_down_timer dual_down_timer_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_dual_down_timer.sv
module tb_dual_down_timer;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cascade = 1'b0;
  logic [1:0]    init = '0, periodic = '0, start = '0, stop = '0;
  logic [CW-1:0] load0 = '0, load1 = '0;
  logic [CW-1:0] count0, count1;
  logic [1:0]    expire, busy;

  dual_down_timer #(.CW(CW)) dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;
    logic [63:0] val;
    int          cyc;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return {32'b0, count0};
      1: return {32'b0, count1};
      2: return {62'b0, expire};
      3: return {62'b0, busy};
      default: return {count1, count0};
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pick(it.sel) !== it.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, pick(it.sel), it.val);
      end
    end
  end

  task automatic expect_v(input string req, input int sel, input logic [63:0] val);
    item_t it;
    it.req = req; it.sel = sel; it.val = val; it.cyc = cyc;
    q.push_back(it);
  endtask

  task automatic step(input logic [1:0] i, input logic [1:0] s, input logic [1:0] p, input logic tk);
    init = i; start = s; stop = p; tick = tk;
    @(posedge clk); #1;
    init = '0; start = '0; stop = '0; tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 2, 0); expect_v("R1", 3, 0);

    // R2: configure channel 0, single-shot, load 5
    load0 = 5; periodic = 2'b00;
    step(2'b01, 2'b00, 2'b00, 1'b0);
    expect_v("R2", 3, 0); expect_v("R2", 0, 0);
    // R3: start
    step(2'b00, 2'b01, 2'b00, 1'b0);
    expect_v("R3", 0, 5); expect_v("R3", 3, 2'b01);
    // R4: no tick, no change
    step(2'b00, 2'b00, 2'b00, 1'b0);
    step(2'b00, 2'b00, 2'b00, 1'b0);
    expect_v("R4", 0, 5);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R4", 0, 4);
    for (int k = 3; k >= 1; k--) begin
      step(2'b00, 2'b00, 2'b00, 1'b1);
      expect_v("R4", 0, k);
      expect_v("R5", 2, 0);
    end
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R5", 0, 0); expect_v("R5", 2, 2'b01); expect_v("R7", 3, 2'b00);
    step(2'b00, 2'b00, 2'b00, 1'b0);
    expect_v("R5", 2, 0);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R7", 0, 0); expect_v("R7", 3, 0);

    // R3/R6: channel 1 periodic, init and start together, load 2
    load1 = 2; periodic = 2'b10;
    step(2'b10, 2'b10, 2'b00, 1'b0);
    expect_v("R3", 1, 2); expect_v("R3", 3, 2'b10);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 1, 1);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 1, 0); expect_v("R6", 2, 2'b10);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 1, 2); expect_v("R6", 2, 0); expect_v("R6", 3, 2'b10);
    expect_v("R9", 0, 0);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 1, 0); expect_v("R6", 2, 2'b10);
    // R3: restart while running
    step(2'b00, 2'b00, 2'b00, 1'b1);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 1, 1);
    step(2'b00, 2'b10, 2'b00, 1'b1);
    expect_v("R3", 1, 2); expect_v("R3", 2, 0);

    // R8: stop
    step(2'b00, 2'b00, 2'b10, 1'b1);
    expect_v("R8", 1, 2); expect_v("R8", 3, 0);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R8", 1, 2); expect_v("R8", 2, 0);
    step(2'b00, 2'b01, 2'b01, 1'b0);
    expect_v("R8", 3, 0); expect_v("R8", 0, 0);

    // R10/R11: chained
    cascade = 1'b1;
    load0 = 1; load1 = 1; periodic = 2'b00;
    step(2'b01, 2'b01, 2'b00, 1'b0);
    expect_v("R10", 4, 64'h0000_0001_0000_0001); expect_v("R11", 3, 2'b01);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R10", 4, 64'h0000_0001_0000_0000);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R10", 4, 64'h0000_0000_FFFF_FFFF); expect_v("R11", 2, 0); expect_v("R11", 3, 2'b01);
    load0 = 2; load1 = 0;
    step(2'b01, 2'b01, 2'b00, 1'b0);
    expect_v("R10", 4, 64'h2);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R11", 4, 0); expect_v("R11", 2, 2'b01); expect_v("R11", 3, 2'b00);
    load1 = 7;
    step(2'b10, 2'b10, 2'b00, 1'b1);
    expect_v("R11", 3, 0); expect_v("R11", 1, 0); expect_v("R11", 2, 0);
    // chained periodic
    load0 = 1; load1 = 0; periodic = 2'b01;
    step(2'b01, 2'b01, 2'b00, 1'b0);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R11", 4, 0); expect_v("R11", 2, 2'b01); expect_v("R6", 3, 2'b01);
    step(2'b00, 2'b00, 2'b00, 1'b1);
    expect_v("R6", 4, 64'h1); expect_v("R6", 2, 0);

    repeat (2) @(posedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule